// File: doc/BRIEF.md
# Variable-Refresh Vertical Line Counter

This block keeps the vertical position of a display timing generator. It advances a line count once per line-end strobe and wraps it to zero at the end of each frame, raising a one-clock frame-start pulse. In fixed-refresh mode a frame always ends at the programmed maximum line. With variable refresh enabled, an external trigger ends the frame early, once the count has reached the programmed minimum. A trigger that arrives too early is held until the minimum is reached. A mid value can also stand in for the maximum for a set number of frames.

The counter's width caps how many lines a frame can have. Longer frames are produced by an extension mechanism. When the count reaches a programmed stop line, it freezes there and the stalled output goes high. While stalled, a secondary counter absorbs a programmed number of extra lines. Counting then resumes at the stop line plus one. A trigger that arrives during the pause ends the frame at once. Setting the extension count to zero turns the mechanism off.

Top module: `vrr_vline_counter`

## Requirements
- R1: After reset, vcount is 0 and both stalled and frame_start are low.
- R2: vcount changes only on a clock where line_end is high. Without the frame-ending, stall or resume cases, each line_end raises vcount by exactly one.
- R3: With vrr_en low, the line_end seen while vcount equals vmax ends the frame. vmax holds the desired line total minus one. A pulse on trig has no effect in this mode.
- R4: When a line_end ends a frame, vcount becomes 0 and frame_start is high for that one clock only.
- R5: With vrr_en high, a trig coinciding with a line_end while vcount is at least vmin ends the frame on that line_end. Without any trigger, the frame ends at vmax.
- R6: With vrr_en high, a trig received while vcount is below vmin is held pending. The frame then ends on the first line_end at which vcount is at least vmin. The pending trigger is dropped at every frame end.
- R7: When mid_en rises while vrr_en is high and vmid is nonzero, the next mid_frames frames end at vmid instead of vmax. Later frames end at vmax again.
- R8: A line_end seen while vcount equals stop_line, with ext_count nonzero, holds vcount and raises stalled. vcount then stays at stop_line for ext_count line_ends in total. The next line_end clears stalled and sets vcount to stop_line+1.
- R9: While stalled, with vrr_en high and vmin not above stop_line, a trig on a line_end ends the frame immediately: vcount becomes 0 and stalled clears.
- R10: With ext_count equal to 0, stalled never rises and vcount passes stop_line without pausing.
- R11: With vmin equal to vmax and vrr_en low, a frame with extension lasts vmax+1+ext_count line_ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_end | input | 1 | One-clock strobe at the end of every line |
| trig | input | 1 | One-clock manual frame-end trigger |
| vrr_en | input | 1 | Enables variable refresh |
| vmin | input | VW | Minimum line count, total minus one |
| vmax | input | VW | Maximum line count, total minus one |
| vmid | input | VW | Mid line count used in place of vmax |
| mid_en | input | 1 | Rising edge arms mid replacement |
| mid_frames | input | FW | Number of frames that use vmid |
| stop_line | input | VW | Line at which the count freezes |
| ext_count | input | EW | Extra lines absorbed while frozen, 0 disables |
| vcount | output | VW | Current vertical line count |
| stalled | output | 1 | Count is frozen at stop_line |
| frame_start | output | 1 | One-clock pulse when a new frame begins |

## Verification
The assertions assume several things about the inputs. The configuration inputs are quasi-static, so stop_line and ext_count do not move while the count is frozen. stop_line lies below vmax, and line_end and trig are single-clock pulses. The stimulus changes configuration only between frames, while vcount sits at 0 and no strobe is in flight. It drives trig only together with a line_end, and every extended case keeps the stop line below the frame's last line.

// File: rtl/vrr_vline_pkg.sv
package vrr_vline_pkg;
  typedef struct packed {
    logic fend;
    logic enter;
    logic leave;
  } line_step_t;
endpackage

// File: rtl/vrr_trig_hold.sv
module vrr_trig_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic vrr_en,
  input  logic trig,
  input  logic clear,
  output logic trig_now
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (clear)
      pend_d = 1'b0;
    else if (vrr_en && trig)
      pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign trig_now = vrr_en & (trig | pend_q);
endmodule

// File: rtl/vrr_mid_tracker.sv
module vrr_mid_tracker #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vrr_en,
  input  logic          mid_en,
  input  logic          vmid_nz,
  input  logic [FW-1:0] mid_frames,
  input  logic          frame_end,
  output logic          use_mid
);
  logic          arm_q;
  logic [FW-1:0] left_q, left_d;
  logic          arm_rise;

  assign arm_rise = mid_en & ~arm_q;
  assign use_mid  = vrr_en & mid_en & vmid_nz & (left_q != '0);

  always_comb begin
    left_d = left_q;
    if (arm_rise)
      left_d = mid_frames;
    else if (frame_end && use_mid)
      left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      left_q <= '0;
    end else begin
      arm_q  <= mid_en;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/vrr_ext_counter.sv
module vrr_ext_counter #(
  parameter int EW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_end,
  input  logic          enter,
  input  logic          frame_end,
  input  logic [EW-1:0] ext_count,
  output logic          stalled,
  output logic          ext_done
);
  logic [EW-1:0] cnt_q, cnt_d;
  logic          stall_q, stall_d;
  logic          cnt_en;

  assign ext_done = (cnt_q == ext_count - 1'b1);
  assign cnt_en   = frame_end | enter | (line_end & stall_q);

  always_comb begin
    cnt_d   = cnt_q;
    stall_d = stall_q;
    if (frame_end) begin
      cnt_d   = '0;
      stall_d = 1'b0;
    end else if (enter) begin
      cnt_d   = '0;
      stall_d = 1'b1;
    end else if (line_end && stall_q) begin
      if (ext_done) stall_d = 1'b0;
      else          cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stall_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      stall_q <= stall_d;
    end
  end

  assign stalled = stall_q;
endmodule

// File: rtl/vrr_vline_counter.sv
module vrr_vline_counter #(
  parameter int VW = 14,
  parameter int EW = 14,
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_end,
  input  logic          trig,
  input  logic          vrr_en,
  input  logic [VW-1:0] vmin,
  input  logic [VW-1:0] vmax,
  input  logic [VW-1:0] vmid,
  input  logic          mid_en,
  input  logic [FW-1:0] mid_frames,
  input  logic [VW-1:0] stop_line,
  input  logic [EW-1:0] ext_count,
  output logic [VW-1:0] vcount,
  output logic          stalled,
  output logic          frame_start
);
  import vrr_vline_pkg::*;

  localparam logic [VW-1:0] ONE = VW'(1);

  logic [VW-1:0] vcnt_q, vcnt_d, eff_max;
  logic          fs_q;
  logic          trig_now, use_mid, ext_done, stall_w;
  line_step_t    st;

  vrr_trig_hold u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .vrr_en   (vrr_en),
    .trig     (trig),
    .clear    (st.fend),
    .trig_now (trig_now)
  );

  vrr_mid_tracker #(.FW(FW)) u_mid (
    .clk        (clk),
    .rst_n      (rst_n),
    .vrr_en     (vrr_en),
    .mid_en     (mid_en),
    .vmid_nz    (vmid != '0),
    .mid_frames (mid_frames),
    .frame_end  (st.fend),
    .use_mid    (use_mid)
  );

  vrr_ext_counter #(.EW(EW)) u_ext (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_end  (line_end),
    .enter     (st.enter),
    .frame_end (st.fend),
    .ext_count (ext_count),
    .stalled   (stall_w),
    .ext_done  (ext_done)
  );

  assign eff_max = use_mid ? vmid : vmax;

  always_comb begin
    st.fend  = line_end &
               ((trig_now & (vcnt_q >= vmin)) | (~stall_w & (vcnt_q >= eff_max)));
    st.enter = line_end & ~st.fend & ~stall_w &
               (vcnt_q == stop_line) & (ext_count != '0);
    st.leave = line_end & ~st.fend & stall_w & ext_done;
  end

  always_comb begin
    vcnt_d = vcnt_q;
    if (st.fend)
      vcnt_d = '0;
    else if (st.leave)
      vcnt_d = vcnt_q + ONE;
    else if (line_end && !stall_w && !st.enter)
      vcnt_d = vcnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt_q <= '0;
      fs_q   <= 1'b0;
    end else begin
      if (line_end) vcnt_q <= vcnt_d;
      fs_q <= st.fend;
    end
  end

  assign vcount      = vcnt_q;
  assign stalled     = stall_w;
  assign frame_start = fs_q;
endmodule

// File: rtl/vrr_vline_counter_chk.sv
module vrr_vline_counter_chk #(
  parameter int VW = 14,
  parameter int EW = 14,
  parameter int FW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_end,
  input logic          trig,
  input logic          vrr_en,
  input logic [VW-1:0] vmin,
  input logic [VW-1:0] vmax,
  input logic [VW-1:0] vmid,
  input logic          mid_en,
  input logic [FW-1:0] mid_frames,
  input logic [VW-1:0] stop_line,
  input logic [EW-1:0] ext_count,
  input logic [VW-1:0] vcount,
  input logic          stalled,
  input logic          frame_start
);
  assert_fs_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (vcount == '0));

  assert_hold_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(vcount));

  assert_freeze_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> (vcount == stop_line));

  assert_no_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_count == '0) |-> !stalled);

  assert_fixed_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!vrr_en && line_end && !stalled && (vcount < vmax) &&
     !((ext_count != '0) && (vcount == stop_line)))
    |=> (vcount == VW'($past(vcount) + 1'b1)) && !frame_start);

  assert_trig_in_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled && line_end && vrr_en && trig && (vcount >= vmin))
    |=> (frame_start && !stalled));
endmodule

bind vrr_vline_counter vrr_vline_counter_chk #(.VW(VW), .EW(EW), .FW(FW)) chk_i (.*);

// File: tb/vrr_vline_counter_tb_top.sv
module vrr_vline_counter_tb_top;
  localparam int VW = 8;
  localparam int EW = 8;
  localparam int FW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          line_end, trig, vrr_en, mid_en;
  logic [VW-1:0] vmin, vmax, vmid, stop_line;
  logic [FW-1:0] mid_frames;
  logic [EW-1:0] ext_count;
  logic [VW-1:0] vcount;
  logic          stalled, frame_start;

  typedef struct {
    int    v;
    bit    st;
    bit    fs;
    string req;
  } exp_t;

  exp_t  exp_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  vrr_vline_counter #(.VW(VW), .EW(EW), .FW(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .trig(trig),
    .vrr_en(vrr_en), .vmin(vmin), .vmax(vmax), .vmid(vmid),
    .mid_en(mid_en), .mid_frames(mid_frames), .stop_line(stop_line),
    .ext_count(ext_count), .vcount(vcount), .stalled(stalled),
    .frame_start(frame_start)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: compare after every line_end edge
  always @(posedge clk) begin
    if (rst_n && line_end) begin
      exp_t e;
      #2;
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_req, 0, -1);
      end else begin
        e = exp_q.pop_front();
        chk(int'(vcount) == e.v, {e.req, " vcount"}, int'(vcount), e.v);
        chk(stalled == e.st, {e.req, " stalled"}, int'(stalled), int'(e.st));
        chk(frame_start == e.fs, {e.req, " frame_start"}, int'(frame_start), int'(e.fs));
      end
    end
  end

  task automatic step(exp_t e, bit tg);
    exp_q.push_back(e);
    @(negedge clk); line_end = 1'b1; trig = tg;
    @(negedge clk); line_end = 1'b0; trig = 1'b0;
  endtask

  // one frame starting at vcount 0; tp = step index carrying a trigger, -1 for none
  task automatic run_frame(int last, int stop, int ext, int tp, string req);
    exp_t seq[$];
    int v = 0;
    int endi;
    while (1) begin
      if (v == last) begin
        seq.push_back('{0, 1'b0, 1'b1, req});
        break;
      end
      if (v == stop && ext > 0) begin
        for (int k = 0; k < ext; k++) seq.push_back('{stop, 1'b1, 1'b0, req});
        v = stop + 1;
      end else begin
        v++;
      end
      seq.push_back('{v, 1'b0, 1'b0, req});
    end
    endi = seq.size() - 1;
    if (vrr_en && tp >= 0) begin
      for (int s = tp; s < endi; s++) begin
        int prev = (s == 0) ? 0 : seq[s-1].v;
        if (prev >= int'(vmin)) begin
          endi = s;
          break;
        end
      end
    end
    for (int s = 0; s <= endi; s++) begin
      if (s == endi) step('{0, 1'b0, 1'b1, req}, s == tp);
      else           step(seq[s], s == tp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; line_end = 1'b0; trig = 1'b0;
    vrr_en = 1'b0; mid_en = 1'b0; mid_frames = '0;
    vmin = 8'd0; vmax = 8'd9; vmid = 8'd0;
    stop_line = 8'd255; ext_count = '0;
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(vcount == '0, "R1 vcount", int'(vcount), 0);
    chk(!stalled, "R1 stalled", int'(stalled), 0);
    chk(!frame_start, "R1 frame_start", int'(frame_start), 0);

    // R2 no movement without line_end
    step('{1, 1'b0, 1'b0, "R2"}, 1'b0);
    idle(5);
    chk(vcount == 8'd1, "R2 idle hold", int'(vcount), 1);
    step('{2, 1'b0, 1'b0, "R2"}, 1'b0);
    // finish the frame: 3..9 then wrap
    for (int k = 3; k <= 9; k++) step('{k, 1'b0, 1'b0, "R3"}, 1'b0);
    step('{0, 1'b0, 1'b1, "R3"}, 1'b0);
    idle(1);
    chk(!frame_start, "R4 one-clock pulse", int'(frame_start), 0);

    // R3 trigger ignored in fixed mode
    cur_req = "R3";
    vmin = 8'd2;
    run_frame(9, 255, 0, 4, "R3");

    // R5 variable refresh
    vrr_en = 1'b1; vmin = 8'd5; vmax = 8'd12; idle(2);
    run_frame(12, 255, 0, -1, "R5");
    run_frame(12, 255, 0, 8, "R5");
    // R6 early trigger held pending
    run_frame(12, 255, 0, 2, "R6");

    // R7 mid replacement for two frames
    vmid = 8'd7; mid_frames = 4'd2; idle(1);
    mid_en = 1'b1; idle(2);
    run_frame(7, 255, 0, -1, "R7");
    run_frame(7, 255, 0, -1, "R7");
    run_frame(12, 255, 0, -1, "R7");
    mid_en = 1'b0; idle(2);

    // R8 extension, no trigger
    stop_line = 8'd5; ext_count = 8'd4; idle(1);
    run_frame(12, 5, 4, -1, "R8");
    // R9 trigger during the pause
    run_frame(12, 5, 4, 7, "R9");

    // R10 extension disabled at the stop line
    ext_count = '0; vrr_en = 1'b0; stop_line = 8'd4; idle(1);
    run_frame(12, 4, 0, -1, "R10");

    // R11 fixed long frame
    vmin = 8'd20; vmax = 8'd20; stop_line = 8'd15; ext_count = 8'd6; idle(1);
    run_frame(20, 15, 6, -1, "R11");
    run_frame(20, 15, 6, 3, "R11");

    idle(3);
    chk(exp_q.size() == 0, "R2 queue drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule